// File: doc/BRIEF.md
# Self-Clearing Reset Pulse Sequencer

This block produces one complete reset cycle for a single peripheral domain each time software sets a request bit. It first gates the domain clock off, then drives the domain reset high for a programmed number of timebase ticks. It then drops reset and keeps the clock gated for a second programmed number of ticks. Finally it re-enables the clock, clears the request bit by itself and raises a sticky completion flag.

Timing comes from a tick input that pulses once every quarter microsecond (a 4 MHz strobe in the system clock domain). Each phase length is an 8-bit tick count, so each phase lasts at most 63.75 µs and the full sequence at most 127.5 µs. A count of zero gives a one-tick phase; the phase is never skipped. Software uses one 32-bit register through a plain write strobe and a combinational read bus.

Top module: `rst_pulse_seq`

## Requirements
- R1: After reset, the read bus returns all zeros, `dom_rst_o` is low and `dom_clk_en_o` is high.
- R2: The register holds the request at bit 0, the reset-hold length at bits 15:8, the clock-stop length at bits 23:16 and the done flag at bit 31; every other bit reads as 0. A write made while idle with bit 0 clear stores both lengths and starts nothing.
- R3: A write made while idle with bit 0 set causes the following. The request reads 1 in the next cycle. `dom_clk_en_o` falls one cycle later. Exactly one clock-gated cycle with reset still low comes before `dom_rst_o` rises.
- R4: `dom_rst_o` stays high until the hold-length count of ticks have been sampled. It falls in the cycle right after the cycle that carries the last of those ticks. The clock stays gated throughout.
- R5: Once reset falls, `dom_clk_en_o` stays low with reset low until the stop-length count of ticks have been sampled. It then rises in the cycle right after the cycle that carries the last of those ticks.
- R6: In the first cycle with the clock re-enabled, the request still reads 1 and done reads 0. In the next cycle the request reads 0 and done reads 1.
- R7: The done flag stays at 1 until a write with bit 31 set clears it. Writes with bit 31 clear leave it unchanged.
- R8: While a sequence is in progress, writes leave the request and both lengths unchanged and start no second sequence.
- R9: A length field of 0 gives a phase of exactly one tick, the same as a field of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Quarter-microsecond timebase strobe, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Live register contents |
| dom_rst_o | output | 1 | Domain reset, active high |
| dom_clk_en_o | output | 1 | Domain clock enable, low while the clock is stopped |

## Verification
A start write appears on the read bus one cycle after the write cycle. The clock enable drops one cycle after that, and reset rises one cycle after that. Each phase ends in the cycle after the cycle carrying its final tick. The request and done bits change one cycle after the clock enable comes back. A done clear is visible one cycle after its write. The bench advances one cycle at a time and samples just after each rising edge. It counts ticks against the outputs seen in that same cycle, so each expected change is checked in exactly the cycle where it is due. The bench drives ticks every cycle, every fourth cycle, and at random, so phase ends land at different offsets.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_STOP_PRE  = 3'd1,
    ST_HOLD      = 3'd2,
    ST_STOP_POST = 3'd3,
    ST_DONE      = 3'd4
  } seq_state_e;
endpackage

// File: rtl/rst_seq_timer.sv
module rst_seq_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic             expire_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_d, len_eff;

  // zero-length field is stretched to a single tick
  assign len_eff = (len_i == '0) ? ONE : len_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = len_eff;
    else if (tick_i && cnt_q != '0) cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = tick_i && (cnt_q == ONE);

  assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             tick_i,
  input  logic [LEN_W-1:0] hold_len_i,
  input  logic [LEN_W-1:0] stop_len_i,
  output logic             dom_rst_o,
  output logic             dom_clk_en_o,
  output logic             busy_o,
  output logic             done_set_o
);
  seq_state_e       state_q, state_d;
  logic             expire, load;
  logic [LEN_W-1:0] len_sel;
  logic             rst_q, clk_en_q;

  assign len_sel = (state_q == ST_HOLD) ? stop_len_i : hold_len_i;
  assign load    = (state_q == ST_STOP_PRE) || ((state_q == ST_HOLD) && expire);

  rst_seq_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .len_i    (len_sel),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (req_i)  state_d = ST_STOP_PRE;
      ST_STOP_PRE:              state_d = ST_HOLD;
      ST_HOLD:      if (expire) state_d = ST_STOP_POST;
      ST_STOP_POST: if (expire) state_d = ST_DONE;
      ST_DONE:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rst_q    <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      rst_q    <= (state_d == ST_HOLD);
      clk_en_q <= !((state_d == ST_STOP_PRE) || (state_d == ST_HOLD) ||
                    (state_d == ST_STOP_POST));
    end
  end

  assign dom_rst_o    = rst_q;
  assign dom_clk_en_o = clk_en_q;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_set_o   = (state_q == ST_DONE);

  assert_gated_before_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_rst_o) |-> ($past(!dom_clk_en_o) && !dom_clk_en_o));
  assert_reset_ends_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_o) |-> ($past(tick_i) && !dom_clk_en_o));
  assert_clock_back_after_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_clk_en_o) |-> ($past(!dom_rst_o) && $past(tick_i)));
endmodule

// File: rtl/rst_seq_regs.sv
module rst_seq_regs #(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int REQ_POS  = 0,
  parameter int HOLD_LSB = 8,
  parameter int STOP_LSB = 16,
  parameter int DONE_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  output logic              req_o,
  output logic [LEN_W-1:0]  hold_len_o,
  output logic [LEN_W-1:0]  stop_len_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int HOLD_MSB = HOLD_LSB + LEN_W - 1;
  localparam int STOP_MSB = STOP_LSB + LEN_W - 1;

  logic             req_q, req_d, done_q, done_d;
  logic [LEN_W-1:0] hold_q, hold_d, stop_q, stop_d;
  logic             locked, unused_wr_bits;

  assign locked         = busy_i || req_q;
  assign unused_wr_bits = ^wr_data_i;

  always_comb begin
    req_d  = req_q;
    hold_d = hold_q;
    stop_d = stop_q;
    done_d = done_q;
    if (wr_en_i && !locked) begin
      req_d  = wr_data_i[REQ_POS];
      hold_d = wr_data_i[HOLD_MSB:HOLD_LSB];
      stop_d = wr_data_i[STOP_MSB:STOP_LSB];
    end
    if (done_set_i) begin
      req_d  = 1'b0;
      done_d = 1'b1;
    end else if (wr_en_i && wr_data_i[DONE_POS]) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      hold_q <= '0;
      stop_q <= '0;
    end else begin
      req_q  <= req_d;
      done_q <= done_d;
      hold_q <= hold_d;
      stop_q <= stop_d;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[REQ_POS]           = req_q;
    rd_data_o[HOLD_MSB:HOLD_LSB] = hold_q;
    rd_data_o[STOP_MSB:STOP_LSB] = stop_q;
    rd_data_o[DONE_POS]          = done_q;
  end

  assign req_o      = req_q;
  assign hold_len_o = hold_q;
  assign stop_len_o = stop_q;

  assert_finish_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_set_i |=> (done_q && !req_q));
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[DONE_POS] && !done_set_i) |=> !done_q);
  assert_locked_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && wr_en_i) |=> ($stable(hold_q) && $stable(stop_q)));
endmodule

// File: rtl/rst_pulse_seq.sv
module rst_pulse_seq #(
  parameter int DATA_W   = 32,
  parameter int LEN_W    = 8,
  parameter int REQ_POS  = 0,
  parameter int HOLD_LSB = 8,
  parameter int STOP_LSB = 16,
  parameter int DONE_POS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              dom_rst_o,
  output logic              dom_clk_en_o
);
  logic             req, busy, done_set;
  logic [LEN_W-1:0] hold_len, stop_len;

  rst_seq_regs #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .REQ_POS(REQ_POS),
    .HOLD_LSB(HOLD_LSB), .STOP_LSB(STOP_LSB), .DONE_POS(DONE_POS)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .busy_i     (busy),
    .done_set_i (done_set),
    .req_o      (req),
    .hold_len_o (hold_len),
    .stop_len_o (stop_len),
    .rd_data_o  (rd_data_o)
  );

  rst_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .tick_i       (tick_i),
    .hold_len_i   (hold_len),
    .stop_len_i   (stop_len),
    .dom_rst_o    (dom_rst_o),
    .dom_clk_en_o (dom_clk_en_o),
    .busy_o       (busy),
    .done_set_o   (done_set)
  );

  assert_reset_implies_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst_o |-> !dom_clk_en_o);
endmodule

// File: tb/rst_pulse_seq_tb.sv
module rst_pulse_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        dom_rst_o;
  logic        dom_clk_en_o;

  int n_vec = 0;
  int n_err = 0;
  int tick_mode = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .dom_rst_o(dom_rst_o), .dom_clk_en_o(dom_clk_en_o)
  );

  function automatic int eff_len(int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic logic [31:0] exp_word(bit req, int hold, int stop, bit done);
    logic [31:0] w;
    w        = '0;
    w[0]     = req;
    w[15:8]  = hold[7:0];
    w[23:16] = stop[7:0];
    w[31]    = done;
    return w;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    case (tick_mode)
      0:       tick_i = 1'b1;
      1:       tick_i = ($urandom_range(0, 2) == 0);
      default: tick_i = ((cyc % 4) == 0);
    endcase
  endtask

  task automatic wr(logic [31:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    step();
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic run_seq(int hold, int stop, bit mid);
    int  pre, hold_t, post_t, phase, guard;
    bit  last_h, last_p, mid_done, exited;
    pre = 0; hold_t = 0; post_t = 0; phase = 0;
    last_h = 0; last_p = 0; mid_done = 0; exited = 0;
    wr(32'h8000_0000);
    chk(rd_data_o[31] == 1'b0, "R7 clear", rd_data_o[31], 0);
    wr(exp_word(1'b1, hold, stop, 1'b0));
    chk(rd_data_o == exp_word(1'b1, hold, stop, 1'b0) && dom_clk_en_o,
        "R3 request visible", rd_data_o, exp_word(1'b1, hold, stop, 1'b0));
    step();
    chk(!dom_clk_en_o && !dom_rst_o, "R3 clock gated", {dom_clk_en_o, dom_rst_o}, 0);
    pre = 1;
    for (guard = 0; guard < 6000 && !exited; guard++) begin
      step();
      if (wr_en_i) begin wr_en_i = 1'b0; wr_data_i = '0; end
      if (phase == 0) begin
        if (dom_rst_o) phase = 1;
        else pre++;
      end
      if (phase == 1) begin
        if (dom_rst_o) begin
          if (dom_clk_en_o) chk(0, "R4 clock on in reset", 1, 0);
          if (tick_i) hold_t++;
          last_h = tick_i;
          if (mid && !mid_done) begin
            mid_done  = 1;
            wr_en_i   = 1'b1;
            wr_data_i = exp_word(1'b1, (hold + 37) % 256, (stop + 91) % 256, 1'b0);
          end
        end else phase = 2;
      end
      if (phase == 2) begin
        if (!dom_clk_en_o) begin
          if (dom_rst_o) chk(0, "R5 reset after release", 1, 0);
          if (tick_i) post_t++;
          last_p = tick_i;
        end else exited = 1;
      end
    end
    chk(exited, "R5 sequence ended", exited, 1);
    chk(pre == 1, "R3 pre-gate cycles", pre, 1);
    chk(hold_t == eff_len(hold) && last_h, "R4 R9 hold ticks", hold_t, eff_len(hold));
    chk(post_t == eff_len(stop) && last_p, "R5 R9 stop ticks", post_t, eff_len(stop));
    chk(rd_data_o == exp_word(1'b1, hold, stop, 1'b0), "R6 R8 first clocked cycle",
        rd_data_o, exp_word(1'b1, hold, stop, 1'b0));
    step();
    chk(rd_data_o == exp_word(1'b0, hold, stop, 1'b1), "R6 finish flags",
        rd_data_o, exp_word(1'b0, hold, stop, 1'b1));
    for (int i = 0; i < 4; i++) begin
      step();
      chk(dom_clk_en_o && !dom_rst_o, "R8 no second sequence", {dom_clk_en_o, dom_rst_o}, 2);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(rd_data_o == 32'h0 && !dom_rst_o && dom_clk_en_o, "R1 in reset",
        rd_data_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    chk(rd_data_o == 32'h0 && !dom_rst_o && dom_clk_en_o, "R1 after reset",
        rd_data_o, 0);

    // field write with request clear: stored, nothing starts
    wr(32'h0FC3_5AF0);
    chk(rd_data_o == exp_word(1'b0, 8'h5A, 8'hC3, 1'b0), "R2 layout",
        rd_data_o, exp_word(1'b0, 8'h5A, 8'hC3, 1'b0));
    for (int i = 0; i < 3; i++) begin
      step();
      chk(dom_clk_en_o && !dom_rst_o, "R2 no start", {dom_clk_en_o, dom_rst_o}, 2);
    end

    tick_mode = 0;
    run_seq(3, 2, 1'b0);
    run_seq(0, 0, 1'b0);
    run_seq(1, 1, 1'b1);
    tick_mode = 2;
    run_seq(5, 7, 1'b1);
    run_seq(0, 255, 1'b0);

    // done stays until a write-one clear
    for (int i = 0; i < 10; i++) step();
    chk(rd_data_o[31] == 1'b1, "R7 sticky", rd_data_o[31], 1);
    wr(exp_word(1'b0, 9, 4, 1'b0));
    chk(rd_data_o == exp_word(1'b0, 9, 4, 1'b1), "R7 zero write keeps done",
        rd_data_o, exp_word(1'b0, 9, 4, 1'b1));
    wr(32'h8000_0000);
    chk(rd_data_o == 32'h0, "R7 write-one clears", rd_data_o, 0);

    tick_mode = 1;
    for (int k = 0; k < 6; k++) begin
      run_seq($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1) == 1);
    end
    run_seq(255, 255, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule